// File: doc/BRIEF.md
# Hit-Triggered Non-Overlapping Two-Phase Generator

This block turns each detection event from a pixel comparator into exactly one two-phase clock cycle for a downstream counter. A cycle is a pulse on `phi1`, a dead interval with both phases low, a pulse on `phi2`, and a second dead interval. The two phases are never high together. The block runs on a fast system clock. Pulse widths and dead intervals are parameters counted in system clock cycles. The defaults are 47 cycles for each phase and 16 cycles of dead time, which at 8 ns give 376 ns and 128 ns.

The `hit` input is asynchronous. It passes through a two-flop synchronizer, and only a rising edge of the synchronized level starts a cycle.

Hits that arrive during a cycle are handled as follows:
- The first such hit is held as one pending request. It starts a new cycle on the clock right after the trailing dead interval ends.
- Further hits in the same cycle are discarded. Each discarded hit is flagged by a one-cycle strobe.

Each phase comes from its own set/clear state stage. A stage cannot be set while the other phase is high.

Top module: `hit_phase_gen`

## Requirements
- R1: A rising edge of `hit` while the block is idle makes `phi1` rise on the third rising clock edge after `hit` goes high. One full cycle follows: first `phi1`, then `phi2`.
- R2: `phi1` and `phi2` are never high in the same clock cycle.
- R3: Every `phi1` pulse and every `phi2` pulse lasts exactly PHASE_W clock cycles.
- R4: `phi2` rises exactly DEAD_W cycles after `phi1` falls. After `phi2` falls, both phases stay low for DEAD_W cycles.
- R5: `busy` rises together with `phi1`. It stays high until the end of the DEAD_W cycles that follow `phi2`.
- R6: A hit edge seen while `busy` is high is held as pending, at most one deep. The pending hit starts the next `phi1` on the first cycle after the trailing dead interval, so back-to-back cycles have a period of 2*PHASE_W + 2*DEAD_W.
- R7: A hit edge seen while `busy` is high and a hit is already pending is dropped. Each dropped hit raises `dropped_hits` for exactly one clock cycle.
- R8: Holding `hit` high for many cycles produces only one two-phase cycle.
- R9: While `rst_n` is low, `phi1`, `phi2`, `busy` and `dropped_hits` are 0. Reset also discards any pending hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | Asynchronous comparator hit level |
| phi1 | output | 1 | First clock phase |
| phi2 | output | 1 | Second clock phase |
| busy | output | 1 | High while a two-phase cycle is in progress |
| dropped_hits | output | 1 | One-cycle strobe for each discarded hit |

## Verification
The bench aims at these corner cases:
- **Hit arriving in the last cycle of the trailing dead interval.** A design that checks only the pending flag there would miss or delay the cycle.
- **Two hits inside one cycle.** A design with no one-deep limit would queue both; one that clears the pending flag too early would lose the first.
- **A hit held high for several periods.** A level-sensitive design would restart cycles over and over.
- **A single-cycle hit.** A design that needs a wider pulse would miss it.
- **Reset with a hit pending.** A design that keeps the pending flag through reset would emit a stray cycle after release.

A cycle-by-cycle timing model in the bench catches:
- any phase pulse one cycle too long or too short;
- any dead interval off by one;
- `busy` dropping early.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PH1  = 3'd1,
    SQ_GAP1 = 3'd2,
    SQ_PH2  = 3'd3,
    SQ_GAP2 = 3'd4
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              level_d_q;

  // shift chain: stage 0 samples the pin, later stages follow
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = async_in;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      level_d_q <= 1'b0;
    end else begin
      chain_q   <= chain_d;
      level_d_q <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~level_d_q;

endmodule

// File: rtl/hps_phase_latch.sv
module hps_phase_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic block_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  // clear wins; set only takes effect while the opposite phase is low
  always_comb begin
    q_d = q_q;
    if (clr_i) begin
      q_d = 1'b0;
    end else if (set_i && !block_i) begin
      q_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/hps_sequencer.sv
module hps_sequencer
  import hps_pkg::*;
#(
  parameter int PHASE_W = 47,
  parameter int DEAD_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic set1_o,
  output logic clr1_o,
  output logic set2_o,
  output logic clr2_o,
  output logic busy_o,
  output logic drop_o
);

  localparam int LIM_MAX = max_of(PHASE_W, DEAD_W);
  localparam int CNT_W   = cnt_bits(LIM_MAX);
  localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(PHASE_W - 1);
  localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(DEAD_W - 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              drop_q, drop_d;

  logic              in_phase;
  logic              active;
  logic              last;
  logic              tail_done;
  logic              start;
  logic              cnt_en;
  logic              cnt_clr;

  always_comb begin
    in_phase  = (state_q == SQ_PH1) || (state_q == SQ_PH2);
    active    = (state_q != SQ_IDLE);
    last      = active && (cnt_q == (in_phase ? PH_LAST : DT_LAST));
    tail_done = (state_q == SQ_GAP2) && last;
    start     = ((state_q == SQ_IDLE) && rise_i) ||
                (tail_done && (pend_q || rise_i));
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start) state_d = SQ_PH1;
      SQ_PH1:  if (last)  state_d = SQ_GAP1;
      SQ_GAP1: if (last)  state_d = SQ_PH2;
      SQ_PH2:  if (last)  state_d = SQ_GAP2;
      SQ_GAP2: if (last)  state_d = start ? SQ_PH1 : SQ_IDLE;
      default:            state_d = SQ_IDLE;
    endcase
  end

  // interval counter with explicit enable
  always_comb begin
    cnt_en  = active || start;
    cnt_clr = start || last || !active;
    cnt_d   = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_clr ? '0 : cnt_q + 1'b1;
    end
  end

  // one-deep pending request and drop strobe
  always_comb begin
    pend_d = pend_q;
    drop_d = 1'b0;
    if (start) begin
      pend_d = pend_q && rise_i;
    end else if (rise_i && active) begin
      if (pend_q) begin
        drop_d = 1'b1;
      end else begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      drop_q  <= drop_d;
    end
  end

  assign set1_o = start;
  assign clr1_o = (state_q == SQ_PH1)  && last;
  assign set2_o = (state_q == SQ_GAP1) && last;
  assign clr2_o = (state_q == SQ_PH2)  && last;
  assign busy_o = active;
  assign drop_o = drop_q;

endmodule

// File: rtl/hit_phase_gen.sv
module hit_phase_gen #(
  parameter int PHASE_W     = 47,
  parameter int DEAD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic phi1,
  output logic phi2,
  output logic busy,
  output logic dropped_hits
);

  localparam int NPH = 2;

  logic           rise;
  logic [NPH-1:0] set_v;
  logic [NPH-1:0] clr_v;
  logic [NPH-1:0] ph_q;

  hps_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hit),
    .rise_o   (rise)
  );

  hps_sequencer #(
    .PHASE_W (PHASE_W),
    .DEAD_W  (DEAD_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .set1_o (set_v[0]),
    .clr1_o (clr_v[0]),
    .set2_o (set_v[1]),
    .clr2_o (clr_v[1]),
    .busy_o (busy),
    .drop_o (dropped_hits)
  );

  // one state stage per phase, each blocked by the other phase
  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      hps_phase_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v[p]),
        .clr_i   (clr_v[p]),
        .block_i (ph_q[NPH-1-p]),
        .q_o     (ph_q[p])
      );
    end
  endgenerate

  assign phi1 = ph_q[0];
  assign phi2 = ph_q[1];

endmodule

// File: rtl/hit_phase_gen_chk.sv
module hit_phase_gen_chk #(
  parameter int PHASE_W = 47,
  parameter int DEAD_W  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic phi1,
  input logic phi2,
  input logic busy,
  input logic dropped_hits
);

  localparam int LIM = (PHASE_W > DEAD_W) ? PHASE_W : DEAD_W;
  localparam int CW  = $clog2(LIM + 2);

  logic [CW-1:0] p1_len, p2_len, gap_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_len  <= '0;
      p2_len  <= '0;
      gap_len <= CW'(DEAD_W);
    end else begin
      p1_len  <= phi1 ? p1_len + 1'b1 : '0;
      p2_len  <= phi2 ? p2_len + 1'b1 : '0;
      if (phi1 || phi2) begin
        gap_len <= '0;
      end else if (gap_len < CW'(DEAD_W)) begin
        gap_len <= gap_len + 1'b1;
      end
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  assert_phi1_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> (p1_len == CW'(PHASE_W)));

  assert_phi2_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> (p2_len == CW'(PHASE_W)));

  assert_mid_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> (gap_len == CW'(DEAD_W)));

  assert_tail_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> (gap_len == CW'(DEAD_W)));

  assert_busy_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phi1 || phi2) |-> busy);

  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> phi1);

  assert_drop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dropped_hits |=> !dropped_hits);

endmodule

bind hit_phase_gen hit_phase_gen_chk #(
  .PHASE_W (PHASE_W),
  .DEAD_W  (DEAD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phi1         (phi1),
  .phi2         (phi2),
  .busy         (busy),
  .dropped_hits (dropped_hits)
);

// File: tb/hit_phase_gen_tb.sv
module hit_phase_gen_tb;

  localparam int PW  = 47;
  localparam int DW  = 16;
  localparam int CYC = 2*PW + 2*DW;

  logic clk = 1'b0;
  logic rst_n;
  logic hit;
  logic phi1, phi2, busy, dropped_hits;

  always #4 clk = ~clk;

  hit_phase_gen #(.PHASE_W(PW), .DEAD_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .phi1(phi1), .phi2(phi2), .busy(busy), .dropped_hits(dropped_hits)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic hit_smp = 1'b0;
  logic rst_smp = 1'b0;

  // timing model state
  bit m_s1, m_s2, m_s3, m_act, m_pend, m_drop;
  int m_t;
  int cyc = 0;
  int last_rise_cyc = 0;
  int rise_gap = 0;
  int dut_rises = 0;
  int dut_drops = 0;
  bit last_phi1 = 1'b0;

  function automatic bit exp_p1(bit act, int t);
    return act && (t < PW);
  endfunction

  function automatic bit exp_p2(bit act, int t);
    return act && (t >= PW + DW) && (t < 2*PW + DW);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    hit_smp <= hit;
    rst_smp <= rst_n;
  end

  always @(negedge clk) begin
    bit rise;
    cyc++;
    if (!rst_n || !rst_smp) begin
      {m_s1, m_s2, m_s3, m_act, m_pend, m_drop} = '0;
      m_t = 0;
    end else begin
      rise = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = hit_smp;
      m_drop = 1'b0;
      if (m_act) begin
        if (m_t == CYC - 1) begin
          if (m_pend || rise) begin
            m_t = 0;
            m_pend = m_pend && rise;
          end else begin
            m_act = 1'b0;
          end
        end else begin
          if (rise) begin
            if (m_pend) m_drop = 1'b1;
            else        m_pend = 1'b1;
          end
          m_t++;
        end
      end else if (rise) begin
        m_act = 1'b1;
        m_t = 0;
      end
      chk(phi1 == exp_p1(m_act, m_t), "R1/R3", "phi1", phi1, exp_p1(m_act, m_t));
      chk(phi2 == exp_p2(m_act, m_t), "R4", "phi2", phi2, exp_p2(m_act, m_t));
      chk(busy == m_act, "R5", "busy", busy, m_act);
      chk(dropped_hits == m_drop, "R7", "dropped_hits", dropped_hits, m_drop);
      chk(!(phi1 && phi2), "R2", "phase overlap", phi1 && phi2, 0);
    end
    if (phi1 && !last_phi1) begin
      dut_rises++;
      rise_gap = cyc - last_rise_cyc;
      last_rise_cyc = cyc;
    end
    last_phi1 = phi1;
    if (dropped_hits) dut_drops++;
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(int w);
    @(posedge clk); #2 hit = 1'b1;
    repeat (w) @(posedge clk);
    #2 hit = 1'b0;
  endtask

  task automatic chk_reset_outs(string tag);
    @(negedge clk);
    chk({phi1, phi2, busy, dropped_hits} == 4'b0, "R9", tag,
        {phi1, phi2, busy, dropped_hits}, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int r0, d0;
    void'($urandom(32'd20251));
    rst_n = 1'b0;
    hit   = 1'b0;
    idle(3);
    chk_reset_outs("outputs in reset");
    @(posedge clk); #2 rst_n = 1'b1;
    idle(5);

    // R1: one isolated short hit gives one cycle
    r0 = dut_rises;
    pulse(3);
    idle(CYC + 10);
    chk(dut_rises - r0 == 1, "R1", "cycles per hit", dut_rises - r0, 1);

    // R1: single-cycle hit is still seen
    r0 = dut_rises;
    pulse(1);
    idle(CYC + 10);
    chk(dut_rises - r0 == 1, "R1", "narrow hit cycles", dut_rises - r0, 1);

    // R8: level held for several periods
    r0 = dut_rises;
    pulse(3*CYC);
    idle(CYC + 10);
    chk(dut_rises - r0 == 1, "R8", "held hit cycles", dut_rises - r0, 1);

    // R6: pending hit runs back to back
    r0 = dut_rises;
    pulse(4);
    idle(60);
    pulse(4);
    idle(2*CYC + 20);
    chk(dut_rises - r0 == 2, "R6", "pending cycles", dut_rises - r0, 2);
    chk(rise_gap == CYC, "R6", "back-to-back period", rise_gap, CYC);

    // R6: hit landing on the last trailing dead cycle
    r0 = dut_rises;
    pulse(2);
    idle(CYC - 3);
    pulse(1);
    idle(2*CYC + 20);
    chk(dut_rises - r0 == 2, "R6", "tail-edge hit cycles", dut_rises - r0, 2);

    // R7: four hits in one cycle -> one pending, two dropped
    r0 = dut_rises; d0 = dut_drops;
    pulse(4); idle(20);
    pulse(4); idle(20);
    pulse(4); idle(20);
    pulse(4);
    idle(3*CYC);
    chk(dut_drops - d0 == 2, "R7", "dropped count", dut_drops - d0, 2);
    chk(dut_rises - r0 == 2, "R7", "cycles with drops", dut_rises - r0, 2);

    // R9: reset with a pending hit discards it
    pulse(4); idle(30);
    pulse(4); idle(10);
    @(posedge clk); #2 rst_n = 1'b0;
    chk_reset_outs("outputs after mid-cycle reset");
    idle(3);
    @(posedge clk); #2 rst_n = 1'b1;
    r0 = dut_rises;
    idle(2*CYC);
    chk(dut_rises - r0 == 0, "R9", "cycles after reset", dut_rises - r0, 0);

    // random hit trains: widths and spacings as multiples of minima
    for (int i = 0; i < 80; i++) begin
      pulse(2 * (1 + $urandom_range(0, 3)));
      idle(15 * (1 + $urandom_range(0, 9)));
    end
    idle(3*CYC);

    summary();
    $finish;
  end

endmodule